// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Debounced Edge Interrupts

This block controls an eight-pin general-purpose I/O port. Software uses it through a small byte-wide register bus. Several registers only steer the pad: output level, output drive, pull-up and Schmitt selection, which appear on dedicated control outputs. Every pin also has an input enable. A pin whose input enable is off reads back 0 and raises no interrupt events.

Each raw input first passes through a two-flop synchronizer, then a per-pin debounce filter. Pins 7..4 share one debounce time and pins 3..0 share another. Each time is picked by a 3-bit code: code 0 bypasses the filter, and code n (1..7) requires the new level to hold for 2^(7+n) clock cycles. An edge detector watches each filtered level and sets a sticky flag on the edge selected for that pin. Flags are cleared by writing 1. A mask decides which flags drive the single level-sensitive interrupt request.

Top module: `gpio8_ctrl`

## Requirements
- R1: After reset, the registers read as follows: output data 0x00, output enable 0x00, pull-up 0xFF, Schmitt 0xFF, mask 0x00, edge select 0x00, flags 0x00, filter control 0x00, input enable 0xFF. irq is 0.
- R2: A write lands in the register addressed at that clock edge and reads back at once. Offsets: 0 input (read-only), 1 output data, 2 output enable, 3 pull-up, 4 Schmitt, 5 mask, 6 edge select, 7 flags, 8 filter control, 9 input enable. All other offsets read 0. pin_out, pin_oe, pull_en and schmitt_en mirror offsets 1 to 4.
- R3: In the filter control register, bits 6..4 hold the code for pins 7..4 and bits 2..0 hold the code for pins 3..0. Bits 7 and 3 always read 0.
- R4: With code 0, a pin change shows at input offset 0 no later than four clock edges after it is applied.
- R5: With code n in 1..7, the filtered level changes only after the synchronized input has held the new level for 2^(7+n) consecutive cycles. A shorter excursion is ignored.
- R6: Each 4-pin group is filtered using only its own code.
- R7: Edge select bit 0 gives a rising-edge trigger and bit 1 gives a falling-edge trigger. Each filtered edge of the selected kind sets the pin's flag once, and the other kind of edge sets nothing.
- R8: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R9: Flags set whatever the mask holds. irq is 1 exactly when some flag bit and its mask bit are both 1, and it stays 1 until that is no longer true.
- R10: A pin with input enable 0 reads 0 at input offset 0 and never sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | peripheral clock |
| rst | input | 1 | synchronous active-high reset |
| pin_in | input | 8 | raw pin levels |
| bus_addr | input | 4 | register offset |
| bus_wr | input | 1 | write strobe |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data for bus_addr (combinational) |
| pin_out | output | 8 | output data levels |
| pin_oe | output | 8 | output drive enables |
| pull_en | output | 8 | pull-up enables |
| schmitt_en | output | 8 | Schmitt input selects |
| irq | output | 1 | masked interrupt request |

## Verification
The hardest case to reach is the boundary of the debounce window. The bench must show that a level held just short of 2^(7+n) cycles leaves the filtered value untouched, while the same level held a few cycles longer changes it. To get there, the bench programs the smallest and next-smallest codes and applies a level change. It samples the input register at counts on either side of the expected switch point. It also applies a 100-cycle glitch against a 256-cycle window with falling edges selected, so that a wrongly passed glitch would leave a flag behind. Driving both groups at once, with different codes, shows that the two group filters are independent.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PORT_W   = 8;
    localparam int GROUP_W  = 4;
    localparam int CODE_W   = 3;
    localparam int BASE_LOG = 8;
    localparam int CNT_W    = BASE_LOG + (2 ** CODE_W) - 2;
    localparam int ADDR_W   = 4;

    typedef enum logic [ADDR_W-1:0] {
        OFS_IN   = 4'd0,
        OFS_OUT  = 4'd1,
        OFS_OE   = 4'd2,
        OFS_PULL = 4'd3,
        OFS_SCHM = 4'd4,
        OFS_MASK = 4'd5,
        OFS_EDGE = 4'd6,
        OFS_FLAG = 4'd7,
        OFS_FILT = 4'd8,
        OFS_IEN  = 4'd9
    } reg_ofs_e;

    typedef struct packed {
        logic [PORT_W-1:0] dout;
        logic [PORT_W-1:0] oe;
        logic [PORT_W-1:0] pull;
        logic [PORT_W-1:0] schm;
        logic [PORT_W-1:0] mask;
        logic [PORT_W-1:0] fall_sel;
        logic [PORT_W-1:0] ien;
        logic [CODE_W-1:0] code_hi;
        logic [CODE_W-1:0] code_lo;
    } port_cfg_t;

    // last count value of a nonzero filter code: 2^(BASE_LOG-1+code) - 1
    function automatic logic [CNT_W-1:0] filt_last(input logic [CODE_W-1:0] code);
        logic [CNT_W:0] span;
        span = (CNT_W+1)'(1) << (BASE_LOG - 1 + int'(code));
        return CNT_W'(span - (CNT_W+1)'(1));
    endfunction
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [PORT_W-1:0]    bus_wdata,
    input  logic [PORT_W-1:0]    in_view,
    input  logic [PORT_W-1:0]    flag_q,
    output port_cfg_t            cfg_q,
    output logic [PORT_W-1:0]    flag_clr,
    output logic [PORT_W-1:0]    bus_rdata
);
    localparam int PAD = GROUP_W - CODE_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.dout     <= '0;
            cfg_q.oe       <= '0;
            cfg_q.pull     <= '1;
            cfg_q.schm     <= '1;
            cfg_q.mask     <= '0;
            cfg_q.fall_sel <= '0;
            cfg_q.ien      <= '1;
            cfg_q.code_hi  <= '0;
            cfg_q.code_lo  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_OUT:  cfg_q.dout     <= bus_wdata;
                OFS_OE:   cfg_q.oe       <= bus_wdata;
                OFS_PULL: cfg_q.pull     <= bus_wdata;
                OFS_SCHM: cfg_q.schm     <= bus_wdata;
                OFS_MASK: cfg_q.mask     <= bus_wdata;
                OFS_EDGE: cfg_q.fall_sel <= bus_wdata;
                OFS_IEN:  cfg_q.ien      <= bus_wdata;
                OFS_FILT: begin
                    cfg_q.code_hi <= bus_wdata[GROUP_W +: CODE_W];
                    cfg_q.code_lo <= bus_wdata[0 +: CODE_W];
                end
                default: ;
            endcase
        end
    end

    assign flag_clr = (bus_wr && bus_addr == OFS_FLAG) ? bus_wdata : '0;

    always_comb begin
        case (bus_addr)
            OFS_IN:   bus_rdata = in_view;
            OFS_OUT:  bus_rdata = cfg_q.dout;
            OFS_OE:   bus_rdata = cfg_q.oe;
            OFS_PULL: bus_rdata = cfg_q.pull;
            OFS_SCHM: bus_rdata = cfg_q.schm;
            OFS_MASK: bus_rdata = cfg_q.mask;
            OFS_EDGE: bus_rdata = cfg_q.fall_sel;
            OFS_FLAG: bus_rdata = flag_q;
            OFS_FILT: bus_rdata = {{PAD{1'b0}}, cfg_q.code_hi, {PAD{1'b0}}, cfg_q.code_lo};
            OFS_IEN:  bus_rdata = cfg_q.ien;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              raw,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    output logic              gated,
    output logic              level
);
    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[0], raw};
    end

    assign gated = sync_q[1] & en;
    assign last  = filt_last(code);

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
            cnt_q <= '0;
        end else if (code == '0) begin
            level <= gated;
            cnt_q <= '0;
        end else if (gated == level) begin
            cnt_q <= '0;
        end else if (cnt_q >= last) begin
            level <= gated;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] level,
    input  logic [PORT_W-1:0] ien,
    input  logic [PORT_W-1:0] fall_sel,
    input  logic [PORT_W-1:0] mask,
    input  logic [PORT_W-1:0] flag_clr,
    output logic [PORT_W-1:0] flag_q,
    output logic              irq
);
    logic [PORT_W-1:0] prev_q;
    logic [PORT_W-1:0] event_w;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    always_comb begin
        for (int i = 0; i < PORT_W; i++) begin
            event_w[i] = ien[i] & (fall_sel[i] ? (prev_q[i] & ~level[i])
                                               : (~prev_q[i] & level[i]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & ~flag_clr) | event_w;
    end

    assign irq = |(flag_q & mask);
endmodule

// File: rtl/gpio8_ctrl.sv
module gpio8_ctrl
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        pin_in,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [7:0]        pin_out,
    output logic [7:0]        pin_oe,
    output logic [7:0]        pull_en,
    output logic [7:0]        schmitt_en,
    output logic              irq
);
    port_cfg_t         cfg_q;
    logic [PORT_W-1:0] flag_q;
    logic [PORT_W-1:0] flag_clr;
    logic [PORT_W-1:0] filt_lvl;
    logic [PORT_W-1:0] gated_in;
    logic [PORT_W-1:0] in_view;
    logic [PORT_W-1:0] ien_w;

    assign ien_w   = cfg_q.ien;
    assign in_view = filt_lvl & cfg_q.ien;

    gpio_regfile u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .in_view(in_view), .flag_q(flag_q),
        .cfg_q(cfg_q), .flag_clr(flag_clr), .bus_rdata(bus_rdata)
    );

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        logic [CODE_W-1:0] code_w;
        if (i >= GROUP_W) begin : g_hi
            assign code_w = cfg_q.code_hi;
        end else begin : g_lo
            assign code_w = cfg_q.code_lo;
        end
        gpio_debounce u_flt (
            .clk(clk), .rst(rst), .raw(pin_in[i]), .en(cfg_q.ien[i]),
            .code(code_w), .gated(gated_in[i]), .level(filt_lvl[i])
        );
    end

    gpio_irq u_irq (
        .clk(clk), .rst(rst), .level(filt_lvl), .ien(cfg_q.ien),
        .fall_sel(cfg_q.fall_sel), .mask(cfg_q.mask), .flag_clr(flag_clr),
        .flag_q(flag_q), .irq(irq)
    );

    assign pin_out    = cfg_q.dout;
    assign pin_oe     = cfg_q.oe;
    assign pull_en    = cfg_q.pull;
    assign schmitt_en = cfg_q.schm;
endmodule

// File: rtl/gpio_chk.sv
module gpio_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic [3:0] bus_addr,
    input logic       irq,
    input logic [7:0] pin_out,
    input logic [7:0] pin_oe,
    input logic [7:0] flag,
    input logic [7:0] ien,
    input logic [7:0] filt,
    input logic [7:0] gin
);
    // R1: reset clears drive and request
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pin_out == 8'h00 && pin_oe == 8'h00 && !irq));

    // R5: a filtered bit only ever moves to the synchronized level it was fed
    assert_filter_target_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((filt ^ $past(filt)) & (filt ^ $past(gin))) == 8'h00));

    // R8: without a write to the flag register no flag bit falls
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == 4'd7) |=> ((flag & $past(flag)) == $past(flag)));

    // R9: request holds while flags and mask are untouched
    assert_irq_level_R9: assert property (@(posedge clk) disable iff (rst)
        (irq && !(bus_wr && (bus_addr == 4'd7 || bus_addr == 4'd5))) |=> irq);

    // R10: a disabled pin never gains a flag
    assert_ien_no_flag_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag & ~$past(flag) & ~$past(ien)) == 8'h00));
endmodule

bind gpio8_ctrl gpio_chk u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .irq(irq),
    .pin_out(pin_out), .pin_oe(pin_oe), .flag(flag_q), .ien(ien_w),
    .filt(filt_lvl), .gin(gated_in)
);

// File: tb/sim_gpio8_ctrl.sv
module sim_gpio8_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin_in = 8'h00;
    logic [3:0] bus_addr = 4'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata, pin_out, pin_oe, pull_en, schmitt_en;
    logic       irq;
    int         checks = 0;
    int         fails = 0;

    always #10 clk = ~clk;

    gpio8_ctrl u0 (
        .clk(clk), .rst(rst), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en),
        .schmitt_en(schmitt_en), .irq(irq)
    );

    // {offset, write data, expected readback}
    localparam logic [19:0] VEC [10] = '{
        {4'd1, 8'hA5, 8'hA5}, {4'd2, 8'h3C, 8'h3C}, {4'd3, 8'h0F, 8'h0F},
        {4'd4, 8'hF0, 8'hF0}, {4'd5, 8'h81, 8'h81}, {4'd6, 8'h5A, 8'h5A},
        {4'd8, 8'hFF, 8'h77}, {4'd8, 8'h35, 8'h35}, {4'd9, 8'h00, 8'h00},
        {4'd12, 8'hFF, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(1);
        // R1 reset values
        rd(4'd1, d); chk("R1 out", d, 8'h00);
        rd(4'd2, d); chk("R1 oe", d, 8'h00);
        rd(4'd3, d); chk("R1 pull", d, 8'hFF);
        rd(4'd4, d); chk("R1 schmitt", d, 8'hFF);
        rd(4'd5, d); chk("R1 mask", d, 8'h00);
        rd(4'd6, d); chk("R1 edge", d, 8'h00);
        rd(4'd7, d); chk("R1 flags", d, 8'h00);
        rd(4'd8, d); chk("R1 filter", d, 8'h00);
        rd(4'd9, d); chk("R1 ien", d, 8'hFF);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R2 / R3 register vectors
        foreach (VEC[i]) begin
            wr(VEC[i][19:16], VEC[i][15:8]);
            rd(VEC[i][19:16], d);
            chk((VEC[i][19:16] == 4'd8) ? "R3 filter fields" : "R2 readback", d, VEC[i][7:0]);
        end
        chk("R2 pin_out", pin_out, 8'hA5);
        chk("R2 pin_oe", pin_oe, 8'h3C);
        chk("R2 pull_en", pull_en, 8'h0F);
        chk("R2 schmitt_en", schmitt_en, 8'hF0);

        // restore a known setup
        wr(4'd9, 8'hFF); wr(4'd8, 8'h00); wr(4'd6, 8'h00); wr(4'd5, 8'h00);
        wait_cyc(6);
        wr(4'd7, 8'hFF);

        // R4 / R7 / R9 unfiltered rising edge
        @(negedge clk); pin_in = 8'h02;
        wait_cyc(5);
        rd(4'd0, d); chk("R4 input follows", d, 8'h02);
        rd(4'd7, d); chk("R9 flag set while masked", d, 8'h02);
        chk("R9 irq masked", {7'd0, irq}, 8'h00);
        wr(4'd5, 8'h02);
        wait_cyc(1);
        chk("R9 irq unmasked", {7'd0, irq}, 8'h01);
        wr(4'd7, 8'h00);
        rd(4'd7, d); chk("R8 write 0 keeps", d, 8'h02);
        chk("R9 irq held", {7'd0, irq}, 8'h01);
        wr(4'd7, 8'h02);
        rd(4'd7, d); chk("R8 write 1 clears", d, 8'h00);
        chk("R9 irq dropped", {7'd0, irq}, 8'h00);

        // R7 falling select
        wr(4'd6, 8'h02);
        @(negedge clk); pin_in = 8'h00;
        wait_cyc(5);
        rd(4'd7, d); chk("R7 falling sets", d, 8'h02);
        wr(4'd7, 8'h02);
        wait_cyc(20);
        rd(4'd7, d); chk("R7 set once", d, 8'h00);
        @(negedge clk); pin_in = 8'h02;
        wait_cyc(5);
        rd(4'd7, d); chk("R7 rising ignored on falling select", d, 8'h00);
        @(negedge clk); pin_in = 8'h00;
        wait_cyc(5);
        wr(4'd7, 8'hFF); wr(4'd5, 8'h00); wr(4'd6, 8'h00);

        // R5 / R6 low group code 1 (256), high group code 0
        wr(4'd8, 8'h01);
        @(negedge clk); pin_in = 8'h11;
        wait_cyc(5);
        rd(4'd0, d); chk("R6 high group unfiltered", d, 8'h10);
        wait_cyc(244);
        rd(4'd0, d); chk("R5 low group still held", d, 8'h10);
        wait_cyc(15);
        rd(4'd0, d); chk("R5 low group after 256", d, 8'h11);
        wr(4'd7, 8'hFF);
        // glitch shorter than the window, falling edges selected
        wr(4'd6, 8'h01);
        @(negedge clk); pin_in = 8'h10;
        wait_cyc(100);
        @(negedge clk); pin_in = 8'h11;
        wait_cyc(300);
        rd(4'd0, d); chk("R5 glitch ignored level", d, 8'h11);
        rd(4'd7, d); chk("R5 glitch ignored flag", d, 8'h00);

        // R5 / R6 high group code 2 (512), low group unfiltered
        wr(4'd8, 8'h20);
        @(negedge clk); pin_in = 8'h00;
        wait_cyc(400);
        rd(4'd0, d); chk("R6 high held with code 2", d, 8'h10);
        wait_cyc(120);
        rd(4'd0, d); chk("R5 high after 512", d, 8'h00);

        // R10 input enable gating
        wr(4'd8, 8'h00); wr(4'd6, 8'h00);
        @(negedge clk); pin_in = 8'h01;
        wait_cyc(5);
        wr(4'd7, 8'hFF);
        wr(4'd9, 8'hFE);
        wait_cyc(3);
        rd(4'd0, d); chk("R10 disabled reads 0", d, 8'h00);
        @(negedge clk); pin_in = 8'h00;
        wait_cyc(5);
        @(negedge clk); pin_in = 8'h01;
        wait_cyc(5);
        rd(4'd7, d); chk("R10 disabled no flag", d, 8'h00);
        wr(4'd9, 8'hFF);
        wait_cyc(5);
        rd(4'd0, d); chk("R10 re-enabled reads pin", d, 8'h01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule